// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the bus-facing slave controller of a small serial EEPROM on a two-wire bus. It watches the clock line and the data line, both already synchronised to the system clock. It spots START and STOP conditions and checks the first byte after a START against a fixed 4-bit device code. When the code matches, it acknowledges on the ninth clock. In a write it loads the next byte into a word pointer and hands every later byte to a synchronous RAM port. In a read it shifts bytes from that RAM port out onto the bus. It never drives the data line high. Its only output to the line is `sda_pull_o`, an enable that pulls the open-drain pad low.

The controller is built around one state machine. Its states are:

| State | Role |
|---|---|
| `ST_IDLE` | Quiet. Waits for a START. |
| `ST_CTRL` | Receives the control byte. |
| `ST_CTRL_ACK` | Acknowledges the control byte. |
| `ST_WADDR` | Receives the word address. |
| `ST_WADDR_ACK` | Acknowledges the word address. |
| `ST_WDATA` | Receives a data byte. |
| `ST_WDATA_ACK` | Acknowledges a data byte. |
| `ST_RD_SEND` | Shifts a read byte out. |
| `ST_RD_ACK` | Samples the master's acknowledge. |

Its transitions are:

- A START sends any state to `ST_CTRL`, and a STOP sends any state to `ST_IDLE`.
- From `ST_CTRL`, a matching code with no write cycle running leads to `ST_CTRL_ACK`. Anything else leads to `ST_IDLE`.
- `ST_CTRL_ACK` goes to `ST_RD_SEND` for a read and to `ST_WADDR` for a write.
- In a write, `ST_WADDR` leads to `ST_WADDR_ACK`, then to `ST_WDATA`. From there the block alternates between `ST_WDATA` and `ST_WDATA_ACK`.
- In a read, `ST_RD_SEND` leads to `ST_RD_ACK`. An acknowledge from the master returns to `ST_RD_SEND`. No acknowledge returns to `ST_IDLE`.

A STOP that closes a write carrying at least one data byte starts an internal write cycle. This cycle is a busy timer lasting `WRITE_CYCLES` system clocks, and every acknowledge is withheld until it ends. The parameter `ADDR_W` must lie between 1 and 8.

Top module: `eeprom_twi_slave`

## Requirements
- R1: When reset is released, `sda_pull_o`, `busy_o` and `mem_we_o` are all 0.
- R2: A control byte whose upper four bits (sent first) are 1010 is acknowledged, whatever the next three bits hold and whatever the last bit (the direction bit: 0 write, 1 read) holds. Acknowledging means `sda_pull_o` is high throughout the high phase of the ninth clock.
- R3: If the upper four bits of the control byte are anything other than 1010, the block does not acknowledge it. The block then never asserts `sda_pull_o` until the next START.
- R4: In a write, the second byte loads the word pointer. Each later byte is acknowledged and produces one `mem_we_o` pulse carrying the current pointer and the received byte.
- R5: After each written byte, only the low `PAGE_W` pointer bits advance by one, wrapping inside the page, and the upper bits stay fixed. A ninth byte to an 8-byte page therefore lands on the page's first written location again.
- R6: A STOP that ends a write holding at least one data byte raises `busy_o` for exactly `WRITE_CYCLES` clocks. A STOP that follows no data byte leaves `busy_o` low.
- R7: While `busy_o` is high, a matching control byte is not acknowledged. Once it falls, the same byte is acknowledged again.
- R8: In a read, the byte at the pointer goes out MSB first, and a bit of 0 is sent as `sda_pull_o` high. `sda_pull_o` changes only while SCL is low.
- R9: After each read byte the whole pointer advances by one, wrapping from its maximum to 0. Reading goes on while the master acknowledges.
- R10: When the master does not acknowledge a read byte, the block releases the line and keeps it released until the next START.
- R11: A START or a STOP in the middle of a byte abandons that byte. After a new START, a complete control byte is received from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line (wired level) |
| sda_pull_o | output | 1 | Pull the data pad low when 1 |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | One-clock write strobe to the array |
| mem_addr_o | output | ADDR_W | Array address (word pointer) |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data, one clock after the address |

## Verification
The bench tries all 16 device codes and all 8 don't-care patterns in both directions. A design that checked the don't-care bits would drop valid addresses, and one that ignored the device code would answer for other devices. A page write of ten bytes that starts near the end of a page catches a pointer that spills into the next page or fails to overwrite earlier bytes. A read that runs past address 0xFF catches a read pointer wrapped at a page boundary instead of at the end of the whole range. The bench also counts the busy window exactly and probes the controller during it, so a timer that is one clock off, or an acknowledge given during the write cycle, shows up. START and STOP are sent in the middle of a byte, which exposes a bit counter that is not cleared.

// File: rtl/twi_eeprom_pkg.sv
`timescale 1ns/1ps
package twi_eeprom_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD_SEND,
        ST_RD_ACK
    } twi_state_e;

endpackage

// File: rtl/twi_line_events.sv
`timescale 1ns/1ps
// Edge and bus-condition detector on the synchronised lines.
module twi_line_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        // data edges while the clock stays high are bus conditions
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/twi_busy_timer.sv
`timescale 1ns/1ps
// Models the nonvolatile write time as a plain down-counter.
module twi_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (go_i) begin
            left_q <= CW'(CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    assign busy_o = (left_q != '0);

endmodule

// File: rtl/twi_word_ptr.sv
`timescale 1ns/1ps
// Word pointer: load, page-local step for writes, full step for reads.
module twi_word_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_page_i,
    input  logic              step_all_i,
    output logic [ADDR_W-1:0] ptr_o
);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] page_next;

    generate
        if (PAGE_W >= ADDR_W) begin : g_whole
            assign page_next = ptr_q + ADDR_W'(1);
        end else begin : g_split
            logic [PAGE_W-1:0] low_next;
            assign low_next  = ptr_q[PAGE_W-1:0] + PAGE_W'(1);
            assign page_next = {ptr_q[ADDR_W-1:PAGE_W], low_next};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= load_val_i;
        end else if (step_page_i) begin
            ptr_q <= page_next;
        end else if (step_all_i) begin
            ptr_q <= ptr_q + ADDR_W'(1);
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/eeprom_twi_slave.sv
`timescale 1ns/1ps
module eeprom_twi_slave
    import twi_eeprom_pkg::*;
#(
    parameter logic [3:0] DEV_CODE     = 4'b1010,
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_W       = 3,
    parameter int         WRITE_CYCLES = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [BYTE_W-1:0] mem_wdata_o,
    input  logic [BYTE_W-1:0] mem_rdata_i
);

    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    twi_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q, bit_cnt_d;
    logic              full_q, full_d;
    logic [BYTE_W-1:0] rx_q, rx_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic              rw_q, rw_d;
    logic              mack_q, mack_d;
    logic              seen_q, seen_d;

    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic ptr_load, ptr_step_page, ptr_step_all, wr_strobe, busy_go;
    logic receiving, shifting;
    logic [ADDR_W-1:0] ptr;

    twi_line_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (bus_start),
        .stop_o    (bus_stop)
    );

    twi_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (busy_go),
        .busy_o(busy_o)
    );

    twi_word_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ptr_load),
        .load_val_i (rx_q[ADDR_W-1:0]),
        .step_page_i(ptr_step_page),
        .step_all_i (ptr_step_all),
        .ptr_o      (ptr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            full_q    <= 1'b0;
            rx_q      <= '0;
            tx_q      <= '1;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            seen_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            bit_cnt_q <= bit_cnt_d;
            full_q    <= full_d;
            rx_q      <= rx_d;
            tx_q      <= tx_d;
            rw_q      <= rw_d;
            mack_q    <= mack_d;
            seen_q    <= seen_d;
        end
    end

    assign receiving = (state_q == ST_CTRL) || (state_q == ST_WADDR) ||
                       (state_q == ST_WDATA);
    assign shifting  = receiving || (state_q == ST_RD_SEND);

    // next state and datapath
    always_comb begin
        state_d       = state_q;
        bit_cnt_d     = bit_cnt_q;
        full_d        = full_q;
        rx_d          = rx_q;
        tx_d          = tx_q;
        rw_d          = rw_q;
        mack_d        = mack_q;
        seen_d        = seen_q;
        ptr_load      = 1'b0;
        ptr_step_page = 1'b0;
        ptr_step_all  = 1'b0;
        wr_strobe     = 1'b0;
        busy_go       = 1'b0;

        if (bus_start) begin
            state_d   = ST_CTRL;
            bit_cnt_d = '0;
            full_d    = 1'b0;
            seen_d    = 1'b0;
        end else if (bus_stop) begin
            state_d   = ST_IDLE;
            bit_cnt_d = '0;
            full_d    = 1'b0;
            busy_go   = seen_q;
            seen_d    = 1'b0;
        end else begin
            if (scl_rise && shifting && !full_q) begin
                bit_cnt_d = bit_cnt_q + CNT_W'(1);
                full_d    = (bit_cnt_q == LAST_BIT);
                if (receiving) begin
                    rx_d = {rx_q[BYTE_W-2:0], sda_i};
                end
            end

            unique case (state_q)
                ST_IDLE: begin
                end
                ST_CTRL: begin
                    if (scl_fall && full_q) begin
                        bit_cnt_d = '0;
                        full_d    = 1'b0;
                        if (rx_q[BYTE_W-1:BYTE_W-4] == DEV_CODE && !busy_o) begin
                            rw_d    = rx_q[0];
                            state_d = ST_CTRL_ACK;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            tx_d    = mem_rdata_i;
                            state_d = ST_RD_SEND;
                        end else begin
                            state_d = ST_WADDR;
                        end
                    end
                end
                ST_WADDR: begin
                    if (scl_fall && full_q) begin
                        bit_cnt_d = '0;
                        full_d    = 1'b0;
                        ptr_load  = 1'b1;
                        state_d   = ST_WADDR_ACK;
                    end
                end
                ST_WADDR_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (scl_fall && full_q) begin
                        bit_cnt_d     = '0;
                        full_d        = 1'b0;
                        wr_strobe     = 1'b1;
                        ptr_step_page = 1'b1;
                        seen_d        = 1'b1;
                        state_d       = ST_WDATA_ACK;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_WDATA;
                    end
                end
                ST_RD_SEND: begin
                    if (scl_fall) begin
                        if (full_q) begin
                            bit_cnt_d    = '0;
                            full_d       = 1'b0;
                            ptr_step_all = 1'b1;
                            state_d      = ST_RD_ACK;
                        end else begin
                            tx_d = {tx_q[BYTE_W-2:0], 1'b1};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack_d = ~sda_i;
                    end
                    if (scl_fall) begin
                        if (mack_q) begin
                            tx_d    = mem_rdata_i;
                            state_d = ST_RD_SEND;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RD_SEND:                              sda_pull_o = ~tx_q[BYTE_W-1];
            default:                                 sda_pull_o = 1'b0;
        endcase
        mem_we_o    = wr_strobe;
        mem_addr_o  = ptr;
        mem_wdata_o = rx_q;
    end

endmodule

// File: rtl/twi_slave_chk.sv
`timescale 1ns/1ps
module twi_slave_chk
    import twi_eeprom_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PAGE_W       = 3,
    parameter int WRITE_CYCLES = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_pull_o,
    input logic              busy_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input twi_state_e        state_q
);

    localparam int HI = (PAGE_W >= ADDR_W) ? ADDR_W : PAGE_W;

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= 0;
        else        busy_run <= busy_o ? busy_run + 1 : 0;
    end

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (state_q == ST_IDLE && !busy_o && !sda_pull_o));

    assert_idle_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_pull_o);

    assert_write_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (state_q == ST_WDATA_ACK));

    generate
        if (PAGE_W < ADDR_W) begin : g_page
            assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
                mem_we_o |=> (mem_addr_o[ADDR_W-1:HI] == $past(mem_addr_o[ADDR_W-1:HI])));
        end
    endgenerate

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run == WRITE_CYCLES));

    assert_busy_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTRL && busy_o) |=> (state_q != ST_CTRL_ACK));

    assert_sda_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull_o));

endmodule

bind eeprom_twi_slave twi_slave_chk #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_pull_o(sda_pull_o),
    .busy_o    (busy_o),
    .mem_we_o  (mem_we_o),
    .mem_addr_o(mem_addr_o),
    .state_q   (state_q)
);

// File: tb/eeprom_twi_slave_tb.sv
`timescale 1ns/1ps
module eeprom_twi_slave_tb_top;

    localparam int AW = 8;
    localparam int PW = 3;
    localparam int WC = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_pull, busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic sda_bus;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    eeprom_twi_slave #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WC)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_bus),
        .sda_pull_o (sda_pull),
        .busy_o     (busy),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_addr),
        .mem_wdata_o(mem_wdata),
        .mem_rdata_i(mem_rdata)
    );

    // array model driven only by the design's port
    logic [7:0] ram [256];
    logic [7:0] wlog [16];
    int wlog_n;
    logic log_clr = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) ram[i] <= 8'(i * 7 + 3);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            mem_rdata <= ram[mem_addr];
        end
        if (log_clr) wlog_n <= 0;
        else if (rst_n && mem_we) begin
            if (wlog_n < 16) wlog[wlog_n] <= mem_addr;
            wlog_n <= wlog_n + 1;
        end
    end

    // monitors
    logic mon_clr = 1'b0;
    int pull_seen;
    int busy_cnt;
    always @(negedge clk) begin
        if (mon_clr) begin
            pull_seen <= 0;
            busy_cnt  <= 0;
        end else begin
            if (sda_pull) pull_seen <= pull_seen + 1;
            if (busy)     busy_cnt  <= busy_cnt + 1;
        end
    end

    logic [7:0] exp_mem [256];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1; tick(1); mon_clr = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(2); m_scl = 1'b1; tick(2);
        m_sda = 1'b0; tick(2); m_scl = 1'b0; tick(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(2); m_scl = 1'b1; tick(2);
        m_sda = 1'b1; tick(2);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; tick(2); m_scl = 1'b1; tick(4); m_scl = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        bit a1;
        send_bits(b, 8);
        m_sda = 1'b1; tick(2); m_scl = 1'b1; tick(1);
        a1 = ~sda_bus; tick(2);
        acked = a1 & ~sda_bus; tick(1);
        m_scl = 1'b0; tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b, output bit stable);
        logic s1, s2;
        m_sda = 1'b1; stable = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2); m_scl = 1'b1; tick(1); s1 = sda_bus; tick(3); s2 = sda_bus;
            if (s1 != s2) stable = 1'b0;
            b[i] = s1; m_scl = 1'b0; tick(2);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(2); m_scl = 1'b1; tick(4);
        m_scl = 1'b0; tick(1); m_sda = 1'b1; tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit a, st;
        logic [7:0] d;
        logic [7:0] base;
        int bad;

        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
        log_clr = 1'b1; mon_clr = 1'b1;
        tick(5);
        log_clr = 1'b0; mon_clr = 1'b0;
        rst_n = 1'b1; tick(1);
        // R1: quiet outputs after reset
        check(!sda_pull && !busy && !mem_we, "R1", {sda_pull, busy, mem_we}, 0);
        tick(4);

        // R2: every don't-care pattern, both directions; R6 no busy without data
        for (int cs = 0; cs < 8; cs++) begin
            for (int rw = 0; rw < 2; rw++) begin
                bus_start();
                send_byte({4'b1010, 3'(cs), 1'(rw)}, a);
                check(a, "R2", a, 1);
                if (rw == 1) recv_byte(1'b0, d, st);
                bus_stop(); tick(3);
                check(!busy, "R6 no data", busy, 0);
            end
        end

        // R3: every other device code is ignored
        clear_mon();
        for (int code = 0; code < 16; code++) begin
            if (code != 10) begin
                bus_start();
                send_byte({4'(code), 3'b101, 1'b0}, a);
                check(!a, "R3 ctrl", a, 0);
                send_byte(8'h00, a);
                check(!a, "R3 follow", a, 0);
                bus_stop();
            end
        end
        check(pull_seen == 0, "R3 line", pull_seen, 0);

        // R11: START mid-byte, then STOP mid-byte
        bus_start(); send_bits(8'hA0, 4);
        bus_start(); send_byte(8'hA0, a);
        check(a, "R11 restart", a, 1);
        bus_stop();
        bus_start(); send_bits(8'hFF, 5); bus_stop();
        bus_start(); send_byte(8'hA2, a);
        check(a, "R11 stop", a, 1);
        bus_stop(); tick(3);

        // R4/R5: ten bytes from offset 5 of page 0x28
        log_clr = 1'b1; tick(1); log_clr = 1'b0;
        base = 8'h28;
        bus_start();
        send_byte(8'hA0, a); check(a, "R4 ctrl", a, 1);
        send_byte(8'h2D, a); check(a, "R4 addr", a, 1);
        for (int k = 0; k < 10; k++) begin
            d = 8'(k * 13 + 8'h40);
            send_byte(d, a);
            check(a, "R4 data ack", a, 1);
            exp_mem[{base[7:3], 3'(5 + k)}] = d;
        end
        clear_mon();
        bus_stop();
        // R7: probe immediately while busy
        bus_start(); send_byte(8'hA0, a);
        check(!a, "R7 busy", a, 0);
        check(busy, "R7 busy high", busy, 1);
        bus_stop();
        tick(WC + 50);
        check(busy_cnt == WC, "R6 length", busy_cnt, WC);
        check(wlog_n == 10, "R4 count", wlog_n, 10);
        for (int k = 0; k < 10; k++)
            check(wlog[k] == {base[7:3], 3'(5 + k)}, "R5 addr", wlog[k], {base[7:3], 3'(5 + k)});
        bad = 0;
        for (int i = 0; i < 256; i++) if (ram[i] !== exp_mem[i]) bad++;
        check(bad == 0, "R4 contents", bad, 0);

        // R7 recovered, then R8/R9 read across the top of the range
        bus_start();
        send_byte(8'hA0, a); check(a, "R7 after", a, 1);
        send_byte(8'hFD, a); check(a, "R9 addr", a, 1);
        bus_start();
        send_byte(8'hA1, a); check(a, "R8 ctrl", a, 1);
        for (int k = 0; k < 5; k++) begin
            recv_byte(k != 4, d, st);
            check(d == exp_mem[8'(8'hFD + k)], "R9 data", d, exp_mem[8'(8'hFD + k)]);
            check(st, "R8 stable", st, 1);
        end
        // R10: line stays released after no-ack
        clear_mon();
        recv_byte(1'b0, d, st);
        check(d == 8'hFF, "R10 released", d, 8'hFF);
        check(pull_seen == 0, "R10 line", pull_seen, 0);
        bus_stop(); tick(3);
        check(!busy, "R6 read stop", busy, 0);

        // R8: read back the written page from offset 0
        bus_start(); send_byte(8'hA4, a); send_byte(8'h28, a);
        bus_start(); send_byte(8'hA1, a);
        for (int k = 0; k < 8; k++) begin
            recv_byte(k != 7, d, st);
            check(d == exp_mem[8'h28 + k], "R8 page", d, exp_mem[8'h28 + k]);
        end
        bus_stop(); tick(3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule